// File: doc/BRIEF.md
# Sampling Converter Serial Result Port

This block models the digital side of a 16-bit successive-approximation converter. A falling edge on the active-low start input launches a conversion. The active-low busy output stays low for a set number of system clock cycles. The word on `result_in` stands in for the comparator outcome and is captured into a working register when the conversion starts. When the conversion ends, that word moves into a separate output shift register. The word is sent MSB first in two's complement.

Two serial modes are available, chosen by `ext_mode`. With `ext_mode` low, the block produces its own data clock during the next conversion, so each result appears one conversion late. With `ext_mode` high, the host clocks the word out with `dclk_in` whenever it likes. In that mode the end-of-conversion reload is skipped if the host clock is high while the chip is selected. Chip select gates the serial pins and the host clock. A parameter narrows the word to 12 bits. A status flag follows the power-down handshake.

Top module: `sar_serial_port`

## Requirements
- R1: When no conversion is running, a high-to-low change of `conv_n` seen at a clock edge drives `busy_n` low from that edge on. The working register takes `result_in` at the same edge. This happens whatever the state of `cs_n`.
- R2: `busy_n` stays low for exactly L cycles and then returns high. L is the larger of `conv_len` (taken at the start) and 2*RES_W+2. Falling edges of `conv_n` during that time are ignored.
- R3: With `ext_mode`=0, let c be the cycle count since the start (0 to L-1). For c < 2*RES_W, `sdata` carries bit RES_W-1-floor(c/2) of the previous conversion's result, and `dclk_out` is high exactly when c is odd. That makes RES_W clock pulses in total. Outside that window, both pins are low.
- R4: With `ext_mode`=1, the reload at the end of a conversion is skipped if `dclk_in` is 1 and `cs_n` is 0 at that edge. The old contents and read position are kept, and the new result is lost.
- R5: With `ext_mode`=1, `sdata` is 0 after a reload until the first rising edge of `dclk_in`. After rising edge k (1-based), `sdata` holds bit RES_W-k of the word and keeps it until the next rising edge. From rising edge RES_W+1 onward it reads 0.
- R6: While `cs_n`=1, `sdata` and `dclk_out` are 0, and rising edges of `dclk_in` do not advance the read position.
- R7: With `ext_mode`=0 and `cs_n`=1 for a whole conversion, the word sent internally during that conversion is lost. The next conversion sends the newer result.
- R8: Reset sets `busy_n` to 1, clears the shift register to zero and clears `pwr_down`. The first internal-mode transfer after reset therefore sends all zeros.
- R9: `pwr_down` rises when `pd_req` is 1 while `conv_n` is 0. It falls when `pd_req` is 0 while `conv_n` is 1. Otherwise it holds its value.
- R10: `dclk_out` is always 0 when `ext_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_n | input | 1 | Active-low conversion start |
| pd_req | input | 1 | Power-down request |
| ext_mode | input | 1 | 1 = host-supplied data clock, 0 = self-generated |
| cs_n | input | 1 | Active-low select for serial pins and host clock |
| dclk_in | input | 1 | Host data clock (sampled on clk) |
| conv_len | input | LEN_W | Requested conversion length in cycles |
| result_in | input | RES_W | Conversion outcome, two's complement |
| busy_n | output | 1 | Low while converting |
| sdata | output | 1 | Serial result, MSB first |
| dclk_out | output | 1 | Self-generated data clock |
| pwr_down | output | 1 | Power-down status |

## Verification
If the cycle counter or the captured length is wrong, the error shows up as a misplaced `busy_n` rising edge. In internal mode it also shows at once as a shifted `dclk_out` pulse train. A wrong shift register or read position can only be seen in `sdata`. In internal mode that happens one conversion after the fault, and in external mode at the first host clock edge after the fault. A wrong reload decision stays hidden until the following read, which then returns the stale word or the fresh one.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // shortest conversion that fits one full internal transfer plus margin
  function automatic int unsigned min_conv_len(int unsigned w);
    return 2 * w + 2;
  endfunction

  // effective conversion length: request clamped to the minimum
  function automatic int unsigned eff_conv_len(int unsigned req, int unsigned w);
    return (req > min_conv_len(w)) ? req : min_conv_len(w);
  endfunction
endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic             pd_req,
  input  logic [LEN_W-1:0] conv_len,
  input  logic [RES_W-1:0] result_in,
  output logic             busy_n,
  output logic [LEN_W-1:0] cnt,
  output logic             end_evt,
  output logic [RES_W-1:0] work,
  output logic             pwr_down
);
  localparam int MINL = sar_pkg::min_conv_len(RES_W);

  logic             conv_q, busy_q, pd_q;
  logic [LEN_W-1:0] cnt_q, len_q, len_now;
  logic [RES_W-1:0] work_q;
  logic             start_evt, last_cyc;

  assign len_now   = LEN_W'(sar_pkg::eff_conv_len(32'(conv_len), RES_W));
  assign start_evt = busy_q & conv_q & ~conv_n;
  assign last_cyc  = ~busy_q & (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b1;
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= LEN_W'(MINL);
      work_q <= '0;
    end else begin
      conv_q <= conv_n;
      if (start_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        len_q  <= len_now;
        work_q <= result_in;
      end else if (!busy_q) begin
        if (last_cyc) busy_q <= 1'b1;
        else          cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pd_q <= 1'b0;
    else if (pd_req && !conv_n)    pd_q <= 1'b1;
    else if (!pd_req && conv_n)    pd_q <= 1'b0;
  end

  assign busy_n   = busy_q;
  assign cnt      = cnt_q;
  assign end_evt  = last_cyc;
  assign work     = work_q;
  assign pwr_down = pd_q;

  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && conv_q && !conv_n) |=> (!busy_q && cnt_q == '0));
  a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !last_cyc) |=> !busy_q);
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    last_cyc |=> busy_q);
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q < len_q && len_q >= LEN_W'(MINL)));
  a_r9_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(!conv_n && pd_req));
  a_r9_leave: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(conv_n && !pd_req));
endmodule

// File: rtl/sar_int_clk.sv
module sar_int_clk #(
  parameter int RES_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_n,
  input  logic [LEN_W-1:0] cnt,
  output logic             in_win,
  output logic             iclk_hi
);
  localparam int SPAN = 2 * RES_W;

  assign in_win  = ~busy_n & (cnt < LEN_W'(SPAN));
  assign iclk_hi = in_win & cnt[0];

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !iclk_hi);
  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    iclk_hi |=> !iclk_hi);
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             cs_n,
  input  logic             dclk_in,
  input  logic             reload_evt,
  input  logic [RES_W-1:0] load_val,
  input  logic             int_shift,
  output logic             ser_bit
);
  logic [RES_W-1:0] sh_q;
  logic             armed_q, dq, rise, load_ok, take;

  assign rise    = dclk_in & ~dq & ~cs_n;
  assign load_ok = ~ext_mode | ~dclk_in | cs_n;
  assign take    = reload_evt & load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      armed_q <= 1'b0;
      dq      <= 1'b0;
    end else begin
      dq <= dclk_in;
      if (take) begin
        sh_q    <= load_val;
        armed_q <= 1'b0;
      end else if (ext_mode) begin
        if (rise) begin
          if (armed_q) sh_q    <= {sh_q[RES_W-2:0], 1'b0};
          else         armed_q <= 1'b1;
        end
      end else if (int_shift) begin
        sh_q <= {sh_q[RES_W-2:0], 1'b0};
      end
    end
  end

  assign ser_bit = ext_mode ? (armed_q & sh_q[RES_W-1]) : sh_q[RES_W-1];

  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && ext_mode && dclk_in && !cs_n && dq) |=> $stable(sh_q) && $stable(armed_q));
  a_r5_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !armed_q && rise && !take) |=> (armed_q && $stable(sh_q)));
  a_r6_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && cs_n && !reload_evt) |=> $stable(sh_q));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int RES_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic             pd_req,
  input  logic             ext_mode,
  input  logic             cs_n,
  input  logic             dclk_in,
  input  logic [LEN_W-1:0] conv_len,
  input  logic [RES_W-1:0] result_in,
  output logic             busy_n,
  output logic             sdata,
  output logic             dclk_out,
  output logic             pwr_down
);
  logic [LEN_W-1:0] cnt;
  logic [RES_W-1:0] work;
  logic             end_evt, in_win, iclk_hi, ser_bit, int_bit;

  sar_conv_ctrl #(.RES_W(RES_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .pd_req(pd_req),
    .conv_len(conv_len), .result_in(result_in), .busy_n(busy_n),
    .cnt(cnt), .end_evt(end_evt), .work(work), .pwr_down(pwr_down)
  );

  sar_int_clk #(.RES_W(RES_W), .LEN_W(LEN_W)) u_iclk (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .cnt(cnt),
    .in_win(in_win), .iclk_hi(iclk_hi)
  );

  sar_shifter #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .cs_n(cs_n),
    .dclk_in(dclk_in), .reload_evt(end_evt), .load_val(work),
    .int_shift(iclk_hi), .ser_bit(ser_bit)
  );

  assign int_bit  = in_win & ser_bit;
  assign sdata    = ~cs_n & (ext_mode ? ser_bit : int_bit);
  assign dclk_out = ~cs_n & ~ext_mode & iclk_hi;

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sdata && !dclk_out));
  a_r10_no_clk_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !dclk_out);
  a_r3_clk_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_out |-> !busy_n);
endmodule

// File: tb/sim_sar_serial_port.sv
module sim_sar_serial_port;
  localparam int W = 16;
  localparam int LW = 8;
  localparam int MINL = 2 * W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_n = 1'b1, pd_req = 1'b0, ext_mode = 1'b0, cs_n = 1'b0, dclk_in = 1'b0;
  logic [LW-1:0] conv_len = '0;
  logic [W-1:0]  result_in = '0;
  logic busy_n, sdata, dclk_out, pwr_down;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sar_serial_port #(.RES_W(W), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .pd_req(pd_req),
    .ext_mode(ext_mode), .cs_n(cs_n), .dclk_in(dclk_in),
    .conv_len(conv_len), .result_in(result_in), .busy_n(busy_n),
    .sdata(sdata), .dclk_out(dclk_out), .pwr_down(pwr_down)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int req);
    return (req > MINL) ? req : MINL;
  endfunction

  // internal-clock conversion; checks stream of prev word cycle by cycle
  task automatic run_int(input logic [W-1:0] val, input logic [W-1:0] prev,
                         input int req_len, input bit sel_off, input bit glitch);
    int len = eff_len(req_len);
    conv_len = LW'(req_len);
    result_in = val;
    cs_n = sel_off;
    conv_n = 1'b0;
    step();
    chk("R1 busy low after start", busy_n, 0);
    conv_n = 1'b1;
    for (int c = 0; c < len; c++) begin
      chk("R2 busy held low", busy_n, 0);
      if (sel_off) begin
        chk("R6 sdata gated", sdata, 0);
        chk("R6 dclk gated", dclk_out, 0);
      end else if (c < 2 * W) begin
        chk("R3 data bit", sdata, prev[W - 1 - c / 2]);
        chk("R3 clock phase", dclk_out, c % 2);
      end else begin
        chk("R3 idle data", sdata, 0);
        chk("R3 idle clock", dclk_out, 0);
      end
      if (glitch && c == 3) conv_n = 1'b0;
      if (glitch && c == 9) conv_n = 1'b1;
      step();
    end
    chk("R2 busy released", busy_n, 1);
    cs_n = 1'b0;
  endtask

  task automatic run_plain(input logic [W-1:0] val);
    int len = eff_len(int'(conv_len));
    result_in = val;
    conv_n = 1'b0;
    step();
    conv_n = 1'b1;
    repeat (len) step();
    chk("R2 busy released", busy_n, 1);
  endtask

  task automatic read_ext(input logic [W-1:0] val);
    chk("R5 low before first edge", sdata, 0);
    for (int k = 0; k < W + 2; k++) begin
      dclk_in = 1'b1;
      step();
      chk("R5 bit after rise", sdata, (k < W) ? val[W - 1 - k] : 1'b0);
      chk("R10 no clock out", dclk_out, 0);
      dclk_in = 1'b0;
      step();
      chk("R5 bit held through fall", sdata, (k < W) ? val[W - 1 - k] : 1'b0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] vals [6];
    logic [W-1:0] prev;
    vals[0] = 16'h8000; vals[1] = 16'h7FFF; vals[2] = 16'hFFFF;
    vals[3] = 16'h0001; vals[4] = 16'hA5C3; vals[5] = 16'h3C96;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R8 reset state
    chk("R8 busy high", busy_n, 1);
    chk("R8 sdata low", sdata, 0);
    chk("R8 dclk low", dclk_out, 0);
    chk("R8 pwr_down low", pwr_down, 0);

    // internal mode sweep; first transfer shows reset zeros (R8)
    prev = '0;
    for (int i = 0; i < 6; i++) begin
      run_int(vals[i], prev, (i == 2) ? 40 : 0, 1'b0, i == 0);
      prev = vals[i];
      step();
    end
    // R7: deselected conversion loses the word it carried
    run_int(16'h1234, prev, 0, 1'b1, 1'b0);
    step();
    run_int(16'h5555, 16'h1234, 0, 1'b0, 1'b0);
    step();

    // external mode
    ext_mode = 1'b1;
    conv_len = '0;
    run_plain(16'hC0DE);
    step();
    read_ext(16'hC0DE);
    // R4: host clock high at end of conversion blocks reload
    run_plain(16'h9ABC);
    dclk_in = 1'b1;
    run_plain(16'h0F0F);
    chk("R4 old word kept, MSB", sdata, 1'b1);
    dclk_in = 1'b0;
    step();
    dclk_in = 1'b1;
    step();
    chk("R4 old word kept, next bit", sdata, 1'b0);
    dclk_in = 1'b0;
    step();
    run_plain(16'h6D2B);
    step();
    read_ext(16'h6D2B);
    // R6: deselected, reload allowed and host edges ignored; R1 start with cs high
    cs_n = 1'b1;
    dclk_in = 1'b1;
    result_in = 16'hB00F;
    conv_n = 1'b0;
    step();
    chk("R1 start while deselected", busy_n, 0);
    conv_n = 1'b1;
    repeat (MINL) step();
    for (int k = 0; k < 3; k++) begin
      dclk_in = 1'b0; step();
      dclk_in = 1'b1; step();
      chk("R6 sdata low when deselected", sdata, 0);
    end
    dclk_in = 1'b0;
    step();
    cs_n = 1'b0;
    step();
    read_ext(16'hB00F);

    // R9 power-down handshake
    pd_req = 1'b1;
    step();
    chk("R9 no entry with start high", pwr_down, 0);
    pd_req = 1'b0;
    conv_n = 1'b0;
    step();
    pd_req = 1'b1;
    step();
    chk("R9 entered", pwr_down, 1);
    pd_req = 1'b0;
    step();
    chk("R9 held while start low", pwr_down, 1);
    pd_req = 1'b1;
    step();
    conv_n = 1'b1;
    step();
    chk("R9 held while request high", pwr_down, 1);
    pd_req = 1'b0;
    step();
    chk("R9 left", pwr_down, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule